// File: doc/BRIEF.md
# Programmable Memory Strobe Sequencer

This block runs one external memory bank access at a time with programmable timing. A request taken while the sequencer is idle starts an access. The access lasts two cycles plus a programmable extra count. During the access the block drives three active-low strobes: chip enable, output enable and byte enable. It also drives an active-high write-data drive enable and a one-cycle read-data capture pulse. Each strobe edge and the drive-enable edge is placed at half-cycle (phase) resolution. The timing settings are taken from the configuration inputs at the moment the request is accepted.

Phase 2c is the high half of access cycle c and phase 2c+1 is the low half. With N access cycles, a window asserts from its lead offset (in phases, counted from the start) up to its trail offset (in phases, counted back from the end). A wait input freezes the access. After the access, a programmable release gap passes. A single-cycle done pulse then marks the end, and the sequencer goes back to idle.

Top module: `mem_strobe_seq`

## Requirements
- R1: An access lasts N = 2 + cfg_extra cycles (cfg_extra 0 to 15), plus any frozen cycles. Access cycle 0 is the clock cycle right after the edge that accepts the request.
- R2: After the last access cycle, cfg_release cycles (0 to 3) pass with all windows deasserted. Then done is high for exactly one cycle and the sequencer returns to idle.
- R3: dq_oe is high in phases p with cfg_drive_dly <= p < 2N. cfg_drive_dly ranges from 0 to 7 phases.
- R4: ce_n, oe_n and be_n are each low in phases p with fall <= p < 2N - rise. Each strobe has its own fall and rise setting, 0 to 3 phases.
- R5: A window whose lead offset is at or past its end point stays deasserted for the whole access.
- R6: rd_latch is high for one unfrozen cycle. That cycle is cycle N-1 when cfg_late_latch is 1, and cycle N-2 when it is 0.
- R7: If mem_wait is high at the edge that ends a non-final cycle, the next cycle is frozen. The cycle index stays put, and more frozen cycles follow for as long as mem_wait is high at each edge. The first cycle after mem_wait is seen low repeats the held cycle in full.
- R8: The window change due at the edge where mem_wait is sampled high still takes effect. The mid-cycle change in a frozen cycle does not happen, so both halves show the first-half level of the held cycle.
- R9: mem_wait high at the edge that ends the final unfrozen cycle is ignored, and the access ends on time.
- R10: req is acted on only while idle. A request seen during the release gap or the done cycle starts no access.
- R11: During and after reset, and while idle, the strobes are high and dq_oe, rd_latch and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the falling edge places half-cycle window changes |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start an access (taken only while idle) |
| cfg_extra | input | 4 | Extra access cycles beyond two |
| cfg_release | input | 2 | Release gap in cycles |
| cfg_drive_dly | input | 3 | Write-data drive delay in phases |
| cfg_ce_fall | input | 2 | Chip-enable lead offset, phases |
| cfg_ce_rise | input | 2 | Chip-enable trail offset, phases |
| cfg_oe_fall | input | 2 | Output-enable lead offset, phases |
| cfg_oe_rise | input | 2 | Output-enable trail offset, phases |
| cfg_be_fall | input | 2 | Byte-enable lead offset, phases |
| cfg_be_rise | input | 2 | Byte-enable trail offset, phases |
| cfg_late_latch | input | 1 | 1: capture in last cycle; 0: one cycle earlier |
| mem_wait | input | 1 | Freeze request, sampled every access cycle |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| be_n | output | 1 | Byte enable, active low |
| dq_oe | output | 1 | Write-data drive enable, active high |
| rd_latch | output | 1 | Read-data capture cycle marker |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench samples each window in both halves of every cycle. This exposes odd lead and trail offsets, which a design working at whole-cycle resolution would round onto the wrong edge. Wait stimulus covers several cases:
- Freezes that start at cycle 0. A design that does not let the same-edge change through would get stuck one phase early.
- Freezes on the final cycle. A design that extends the access there would move done late.
- Random wait bursts, which check that both halves of a frozen cycle hold one level.

Offsets that leave an empty window check that a reversed interval never asserts. Requests placed in the release gap and done cycle check that a premature start is caught, because it would pull the chip enable low in the next idle cycle.

// File: rtl/mss_pkg.sv
`timescale 1ns/1ps
// Shared types of the memory strobe sequencer.
package mss_pkg;
    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RELEASE = 2'd2,
        ST_DONE    = 2'd3
    } seq_state_e;

    // Windows: three strobes and the data drive enable.
    localparam int NUM_WIN = 4;
    localparam int WIN_DRV = 3;
endpackage

// File: rtl/mss_sequencer.sv
`timescale 1ns/1ps
// Access sequencer: accepts a request while idle, counts access cycles,
// handles wait freezes and the release gap, and flags the done cycle.
// Assumes cfg inputs are stable in the cycle req is accepted.
module mss_sequencer
    import mss_pkg::*;
#(
    parameter int EXTRA_W = 4,
    parameter int REL_W   = 2,
    localparam int CYC_W  = EXTRA_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               mem_wait,
    input  logic [EXTRA_W-1:0] cfg_extra,
    input  logic [REL_W-1:0]   cfg_release,
    output seq_state_e         st,
    output logic [CYC_W-1:0]   cyc,
    output logic [CYC_W-1:0]   last_cyc,
    output logic               frozen,
    output logic               accept
);
    logic [REL_W-1:0] rcnt_q;

    // Request is taken only in idle.
    assign accept = (st == ST_IDLE) && req;

    // State, cycle index, freeze flag and release count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cyc      <= '0;
            last_cyc <= '0;
            frozen   <= 1'b0;
            rcnt_q   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req) begin
                    st       <= ST_ACCESS;
                    cyc      <= '0;
                    frozen   <= 1'b0;
                    last_cyc <= CYC_W'(cfg_extra) + CYC_W'(1);
                    rcnt_q   <= cfg_release;
                end
                ST_ACCESS: begin
                    if (frozen) begin
                        if (!mem_wait) frozen <= 1'b0;
                    end else if (cyc == last_cyc) begin
                        st <= (rcnt_q == '0) ? ST_DONE : ST_RELEASE;
                    end else begin
                        cyc    <= cyc + CYC_W'(1);
                        frozen <= mem_wait;
                    end
                end
                ST_RELEASE: begin
                    if (rcnt_q == REL_W'(1)) st <= ST_DONE;
                    rcnt_q <= rcnt_q - REL_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mss_phase_window.sv
`timescale 1ns/1ps
// One half-cycle-resolution window. It asserts in phases [lead, 2N - trail)
// of the access. The high-half level comes from rising-edge state. The
// low-half level is retimed through a falling-edge register. In a frozen
// cycle both halves show the high-half level.
module mss_phase_window #(
    parameter int CYC_W   = 5,
    parameter int LEAD_W  = 3,
    parameter int TRAIL_W = 2,
    localparam int PH_W   = CYC_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               frozen,
    input  logic [CYC_W-1:0]   cyc,
    input  logic [CYC_W-1:0]   last_cyc,
    input  logic [LEAD_W-1:0]  lead,
    input  logic [TRAIL_W-1:0] trail,
    output logic               win
);
    logic [PH_W-1:0] ph_hi, ph_lo, ph_stop;
    logic            lvl_hi, lvl_lo, lo_q;

    // Phase numbers of both halves and the window's end point.
    always_comb begin
        ph_hi   = {1'b0, cyc, 1'b0};
        ph_lo   = {1'b0, cyc, 1'b1};
        ph_stop = {1'b0, last_cyc, 1'b0} + PH_W'(2) - PH_W'(trail);
    end

    // Levels for the two halves of the current cycle.
    always_comb begin
        lvl_hi = active && (ph_hi >= PH_W'(lead)) && (ph_hi < ph_stop);
        lvl_lo = frozen ? lvl_hi
                        : (active && (ph_lo >= PH_W'(lead)) && (ph_lo < ph_stop));
    end

    // Falling-edge capture of the low-half level.
    always_ff @(negedge clk) begin
        if (!rst_n) lo_q <= 1'b0;
        else        lo_q <= lvl_lo;
    end

    assign win = clk ? lvl_hi : lo_q;
endmodule

// File: rtl/mem_strobe_seq.sv
`timescale 1ns/1ps
// Programmable memory strobe sequencer top. It captures the window settings
// at accept, runs the sequencer, and builds four phase windows (three
// active-low strobes and the drive enable) plus the read latch marker.
module mem_strobe_seq
    import mss_pkg::*;
#(
    parameter int EXTRA_W = 4,
    parameter int REL_W   = 2,
    parameter int DRV_W   = 3,
    parameter int EDGE_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [EXTRA_W-1:0] cfg_extra,
    input  logic [REL_W-1:0]   cfg_release,
    input  logic [DRV_W-1:0]   cfg_drive_dly,
    input  logic [EDGE_W-1:0]  cfg_ce_fall,
    input  logic [EDGE_W-1:0]  cfg_ce_rise,
    input  logic [EDGE_W-1:0]  cfg_oe_fall,
    input  logic [EDGE_W-1:0]  cfg_oe_rise,
    input  logic [EDGE_W-1:0]  cfg_be_fall,
    input  logic [EDGE_W-1:0]  cfg_be_rise,
    input  logic               cfg_late_latch,
    input  logic               mem_wait,
    output logic               ce_n,
    output logic               oe_n,
    output logic               be_n,
    output logic               dq_oe,
    output logic               rd_latch,
    output logic               done
);
    localparam int CYC_W  = EXTRA_W + 1;
    localparam int LEAD_W = (DRV_W > EDGE_W) ? DRV_W : EDGE_W;

    seq_state_e       seq_st;
    logic [CYC_W-1:0] seq_cyc, seq_last;
    logic             seq_frozen, seq_accept, in_access;

    logic [LEAD_W-1:0] lead_in [NUM_WIN];
    logic [EDGE_W-1:0] trail_in[NUM_WIN];
    logic [LEAD_W-1:0] lead_q  [NUM_WIN];
    logic [EDGE_W-1:0] trail_q [NUM_WIN];
    logic              late_q;
    logic [NUM_WIN-1:0] win;

    mss_sequencer #(.EXTRA_W(EXTRA_W), .REL_W(REL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .mem_wait(mem_wait),
        .cfg_extra(cfg_extra), .cfg_release(cfg_release),
        .st(seq_st), .cyc(seq_cyc), .last_cyc(seq_last),
        .frozen(seq_frozen), .accept(seq_accept)
    );

    // Settings ordered by window index.
    always_comb begin
        lead_in[0]        = LEAD_W'(cfg_ce_fall);
        trail_in[0]       = cfg_ce_rise;
        lead_in[1]        = LEAD_W'(cfg_oe_fall);
        trail_in[1]       = cfg_oe_rise;
        lead_in[2]        = LEAD_W'(cfg_be_fall);
        trail_in[2]       = cfg_be_rise;
        lead_in[WIN_DRV]  = LEAD_W'(cfg_drive_dly);
        trail_in[WIN_DRV] = '0;
    end

    // Window settings are captured at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                lead_q[i]  <= '0;
                trail_q[i] <= '0;
            end
            late_q <= 1'b0;
        end else if (seq_accept) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                lead_q[i]  <= lead_in[i];
                trail_q[i] <= trail_in[i];
            end
            late_q <= cfg_late_latch;
        end
    end

    assign in_access = (seq_st == ST_ACCESS);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        mss_phase_window #(.CYC_W(CYC_W), .LEAD_W(LEAD_W), .TRAIL_W(EDGE_W)) u_win (
            .clk(clk), .rst_n(rst_n), .active(in_access), .frozen(seq_frozen),
            .cyc(seq_cyc), .last_cyc(seq_last),
            .lead(lead_q[g]), .trail(trail_q[g]), .win(win[g])
        );
    end

    // Output decode: strobes active low, latch in the chosen unfrozen cycle.
    always_comb begin
        ce_n     = ~win[0];
        oe_n     = ~win[1];
        be_n     = ~win[2];
        dq_oe    = win[WIN_DRV];
        rd_latch = in_access && !seq_frozen &&
                   (seq_cyc == (late_q ? seq_last : seq_last - CYC_W'(1)));
        done     = (seq_st == ST_DONE);
    end
endmodule

// File: rtl/mss_checker.sv
`timescale 1ns/1ps
// Temporal checks on the sequencer, attached to the top by bind.
module mss_checker
    import mss_pkg::*;
#(
    parameter int CYC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             done,
    input logic             mem_wait,
    input seq_state_e       st,
    input logic [CYC_W-1:0] cyc,
    input logic [CYC_W-1:0] last_cyc,
    input logic             frozen
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    access_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACCESS && !frozen && cyc != last_cyc) |=> (st == ST_ACCESS));
    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACCESS && frozen && mem_wait) |=> (frozen && $stable(cyc)));
    // R8
    freeze_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACCESS && !frozen && cyc != last_cyc && mem_wait)
        |=> (frozen && cyc == $past(cyc) + CYC_W'(1)));
    // R9
    last_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACCESS && !frozen && cyc == last_cyc && mem_wait) |=> (st != ST_ACCESS));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RELEASE || st == ST_DONE) |=> (st != ST_ACCESS));
    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && req) |=> (st == ST_ACCESS && cyc == '0 && !frozen));
endmodule

bind mem_strobe_seq mss_checker #(.CYC_W(CYC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .mem_wait(mem_wait),
    .st(seq_st), .cyc(seq_cyc), .last_cyc(seq_last), .frozen(seq_frozen)
);

// File: tb/mem_strobe_seq_tb.sv
`timescale 1ns/1ps
module mem_strobe_seq_tb;
    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, mem_wait = 1'b0;
    logic [3:0] cfg_extra = '0;
    logic [1:0] cfg_release = '0;
    logic [2:0] cfg_drive_dly = '0;
    logic [1:0] cfg_ce_fall = '0, cfg_ce_rise = '0, cfg_oe_fall = '0;
    logic [1:0] cfg_oe_rise = '0, cfg_be_fall = '0, cfg_be_rise = '0;
    logic cfg_late_latch = 1'b0;
    logic ce_n, oe_n, be_n, dq_oe, rd_latch, done;
    int checks = 0, failures = 0, cycles = 0;

    always #5 clk = ~clk;  // 100 MHz

    mem_strobe_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .cfg_extra(cfg_extra),
        .cfg_release(cfg_release), .cfg_drive_dly(cfg_drive_dly),
        .cfg_ce_fall(cfg_ce_fall), .cfg_ce_rise(cfg_ce_rise),
        .cfg_oe_fall(cfg_oe_fall), .cfg_oe_rise(cfg_oe_rise),
        .cfg_be_fall(cfg_be_fall), .cfg_be_rise(cfg_be_rise),
        .cfg_late_latch(cfg_late_latch), .mem_wait(mem_wait),
        .ce_n(ce_n), .oe_n(oe_n), .be_n(be_n), .dq_oe(dq_oe),
        .rd_latch(rd_latch), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit exp_on(int ph, int lead, int trail, int n);
        return (ph >= lead) && (ph < 2 * n - trail);
    endfunction

    function automatic logic [3:0] wins();
        return {dq_oe, ~be_n, ~oe_n, ~ce_n};
    endfunction

    // Idle levels check (R11 / R2 gap).
    task automatic chk_quiet(input string tag);
        chk(wins() == 4'd0 && !rd_latch, tag, int'({wins(), rd_latch}), 0);
    endtask

    // Run one access. wmode: 0 none, 1 random, 2 last-cycle only, 3 two-cycle freeze at start.
    task automatic run_access(input int extra, input int rel, input int drv,
                              input int fa[3], input int ra[3], input int late,
                              input int wmode, input bit hammer);
        int n = extra + 2;
        int lead[4], trail[4];
        int c = 0, ext = 0, tgt;
        bit frz = 0, w;
        string rtag;
        for (int i = 0; i < 3; i++) begin lead[i] = fa[i]; trail[i] = ra[i]; end
        lead[3] = drv; trail[3] = 0;
        tgt = late ? n - 1 : n - 2;
        cfg_extra = 4'(extra); cfg_release = 2'(rel); cfg_drive_dly = 3'(drv);
        cfg_ce_fall = 2'(fa[0]); cfg_ce_rise = 2'(ra[0]);
        cfg_oe_fall = 2'(fa[1]); cfg_oe_rise = 2'(ra[1]);
        cfg_be_fall = 2'(fa[2]); cfg_be_rise = 2'(ra[2]);
        cfg_late_latch = late[0];
        req = 1'b1;
        @(posedge clk);
        forever begin
            #2;
            req = 1'b0;
            if (frz) ext++;
            for (int i = 0; i < 4; i++) begin
                bit e = exp_on(2 * c, lead[i], trail[i], n);
                rtag = frz ? "R8" : (lead[i] >= 2 * n - trail[i]) ? "R5" : (i == 3) ? "R3" : "R4";
                chk(wins()[i] == e, {rtag, " high half"}, wins()[i], e);
            end
            chk(!done, "R2 no done in access", done, 0);
            #5;
            for (int i = 0; i < 4; i++) begin
                bit e = frz ? exp_on(2 * c, lead[i], trail[i], n)
                            : exp_on(2 * c + 1, lead[i], trail[i], n);
                rtag = frz ? "R8" : (lead[i] >= 2 * n - trail[i]) ? "R5" : (i == 3) ? "R3" : "R4";
                chk(wins()[i] == e, {rtag, " low half"}, wins()[i], e);
            end
            chk(rd_latch == (!frz && c == tgt), "R6 latch", rd_latch, int'(!frz && c == tgt));
            case (wmode)
                1: w = ($urandom_range(0, 99) < 25) && ext < 12;
                2: w = (!frz && c == n - 1);
                3: w = (ext < 2) && (c <= 1) && (c == 0 || frz);
                default: w = 1'b0;
            endcase
            mem_wait = w;
            @(posedge clk);
            if (frz) begin
                if (!w) frz = 0;
            end else if (c == n - 1) begin
                break;
            end else begin
                c++;
                frz = w;
            end
        end
        mem_wait = 1'b0;
        if (hammer) req = 1'b1;
        for (int r = 0; r < rel; r++) begin
            #2;
            chk_quiet("R2 release gap");
            chk(!done, "R2 done early", done, 0);
            @(posedge clk);
        end
        #2;
        chk(done, (wmode == 2) ? "R9 end on time" : (ext > 0) ? "R7 extended end" : "R1 length", done, 1);
        chk_quiet("R2 quiet in done");
        #5;
        req = 1'b0;
        @(posedge clk);
        #2;
        chk(!done, "R2 done single", done, 0);
        chk_quiet(hammer ? "R10 busy req ignored" : "R11 idle");
        #5;
        chk_quiet(hammer ? "R10 busy req ignored low" : "R11 idle low");
        @(posedge clk);
        #2;
        chk_quiet(hammer ? "R10 still idle" : "R11 idle next");
        #5;
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int fa[3], ra[3];
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        chk_quiet("R11 in reset");
        chk(!done, "R11 done in reset", done, 0);
        #5;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk_quiet("R11 after reset");
        #5;
        // Directed: offsets 0, minimum length, no gap.
        fa = '{0, 0, 0}; ra = '{0, 0, 0};
        run_access(0, 0, 0, fa, ra, 1, 0, 0);
        // Directed: odd offsets, each strobe different.
        fa = '{1, 2, 3}; ra = '{3, 1, 2};
        run_access(3, 2, 5, fa, ra, 0, 0, 0);
        // Directed: empty windows (R5) on shortest access.
        fa = '{3, 3, 2}; ra = '{1, 3, 2};
        run_access(0, 1, 7, fa, ra, 0, 0, 0);
        // Directed: freeze at start (R7, R8).
        fa = '{1, 0, 2}; ra = '{0, 1, 3};
        run_access(2, 1, 3, fa, ra, 1, 3, 0);
        // Directed: wait on final cycle ignored (R9).
        fa = '{0, 1, 0}; ra = '{2, 0, 1};
        run_access(1, 3, 2, fa, ra, 1, 2, 0);
        // Directed: request held through release and done (R10).
        fa = '{0, 0, 0}; ra = '{0, 0, 0};
        run_access(1, 3, 0, fa, ra, 0, 0, 1);
        run_access(15, 0, 0, fa, ra, 1, 0, 1);
        // Random accesses.
        for (int k = 0; k < 250; k++) begin
            for (int i = 0; i < 3; i++) begin
                fa[i] = $urandom_range(0, 3);
                ra[i] = $urandom_range(0, 3);
            end
            run_access($urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 7),
                       fa, ra, $urandom_range(0, 1), $urandom_range(0, 3), k[3:0] == 4'd5);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule